// File: doc/BRIEF.md
# PRBS15 Self-Test Frame Generator

This block produces an endless train of test frames on a nibble-wide transmit interface of the MII kind. Each nibble is 4 bits and there is a transmit-enable strobe. A frame opens with a run of 0x5 nibbles, then one 0xD delimiter nibble, then one fixed 0x5 nibble. After those comes a pseudo-random payload taken from a 15-bit linear feedback shift register with the polynomial x^15 + x^14 + 1. A quiet gap follows with the strobe low. The payload size is given in bytes on an input and is taken afresh at the start of each frame.

The shift register is never reseeded between frames. Frame after frame therefore carries one unbroken stretch of the sequence. A far-end receiver can lock onto the sequence once and then check every later payload bit against its own copy.

A start pulse sets off frame generation. A stop request is held until the current frame and its gap are complete, so a frame is never cut short. Line coding, delimiter symbols, checksums and software access belong to other blocks.

Top module: `prbs_bist_gen`

## Requirements
- R1: After reset the block is idle, with `tx_en_o` low, `txd_o` equal to 0 and the shift register holding all ones.
- R2: A start pulse sampled while idle makes the first preamble nibble appear in the cycle after that clock edge. A start pulse sampled while frames are running has no effect.
- R3: Each frame begins with 15 nibbles of 0x5, then one 0xD nibble, then one 0x5 nibble, and the payload comes after these.
- R4: The byte count `len_i` is sampled at the clock edge that begins the frame's first preamble nibble. A count of N gives 2N-1 payload nibbles, and a count of 0 gives one payload nibble. So the strobe is high for 17 + 2N-1 cycles.
- R5: The shift register steps by taking fb = s[14] XOR s[13] and then s = {s[13:0], fb}. The emitted bit is fb. Four steps make one payload nibble, and the first bit goes to `txd_o[0]`.
- R6: The shift register advances only during payload nibbles and keeps its state across frames, so consecutive payloads continue one sequence.
- R7: The strobe stays high from the first preamble nibble through the last payload nibble. It is then low for exactly 24 cycles before the next frame begins.
- R8: A stop pulse sampled at any point during a frame, including the last gap cycle, lets that frame and its gap finish and then returns the block to idle. A stop pulse sampled while idle has no effect.
- R9: Start and stop sampled in the same idle cycle produce exactly one frame, after which the block returns to idle.
- R10: The shift register never holds the all-zero state.
- R11: `txd_o` is 0 in every cycle in which `tx_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin continuous frame generation |
| stop_i | input | 1 | Request to stop at the next frame boundary |
| len_i | input | LEN_W | Payload length in bytes |
| txd_o | output | 4 | Transmit nibble |
| tx_en_o | output | 1 | Transmit enable |

## Verification
The delicate collision is between the end of a frame's gap and a stop request. In the last gap cycle the block decides whether to start the next frame or go idle. A stop that arrives in exactly that cycle must win. The bench provokes this by watching its reference model and raising stop when the model holds the last gap nibble. It then expects the line to stay idle and not begin another preamble. A second collision is start and stop sampled in the same idle cycle. That case must yield one complete frame and then idle, and the bench judges it by the per-cycle comparison and by the frame-length check.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SFD,
        PH_XTRA,
        PH_PAY,
        PH_GAP
    } phase_t;

    localparam logic [3:0] NIB_PRE  = 4'h5;
    localparam logic [3:0] NIB_SFD  = 4'hD;
    localparam logic [3:0] NIB_XTRA = 4'h5;
    localparam int unsigned NIB_W   = 4;

endpackage

// File: rtl/prbs_nib_step.sv
// Advances a Fibonacci shift register by STEPS positions in one cycle and
// returns the bits produced, first produced bit in position 0.
module prbs_nib_step #(
    parameter int unsigned LFSR_W = 15,
    parameter int unsigned TAP_A  = 15,
    parameter int unsigned TAP_B  = 14,
    parameter int unsigned STEPS  = 4
) (
    input  logic [LFSR_W-1:0] state_i,
    output logic [LFSR_W-1:0] state_o,
    output logic [STEPS-1:0]  bits_o
);

    logic [LFSR_W-1:0] chain [STEPS+1];

    assign chain[0] = state_i;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic fb;
        assign fb          = chain[i][TAP_A-1] ^ chain[i][TAP_B-1];
        assign chain[i+1]  = {chain[i][LFSR_W-2:0], fb};
        assign bits_o[i]   = fb;
    end

    assign state_o = chain[STEPS];

endmodule

// File: rtl/bist_frame_ctrl.sv
// Frame phase sequencer: preamble, delimiter, extra nibble, payload, gap.
module bist_frame_ctrl
    import prbs_bist_pkg::*;
#(
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned PRE_N  = 15,
    parameter int unsigned GAP_N  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [LEN_W-1:0] len_i,
    output phase_t           phase_o,
    output logic             pay_adv_o
);

    localparam int unsigned CNT_MAX = (PRE_N > GAP_N) ? PRE_N : GAP_N;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam int unsigned PAY_W   = LEN_W + 1;

    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] cnt;
        logic [PAY_W-1:0] left;
        logic [LEN_W-1:0] len;
        logic             stop_pend;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  adv_d;

    always_comb begin
        ctrl_d = ctrl_q;
        adv_d  = 1'b0;
        if (ctrl_q.phase != PH_IDLE) begin
            ctrl_d.stop_pend = ctrl_q.stop_pend | stop_i;
        end
        case (ctrl_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    ctrl_d.phase     = PH_PRE;
                    ctrl_d.cnt       = '0;
                    ctrl_d.len       = len_i;
                    ctrl_d.stop_pend = stop_i;
                end
            end
            PH_PRE: begin
                if (ctrl_q.cnt == CNT_W'(PRE_N - 1)) begin
                    ctrl_d.phase = PH_SFD;
                    ctrl_d.cnt   = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            PH_SFD: begin
                ctrl_d.phase = PH_XTRA;
            end
            PH_XTRA: begin
                ctrl_d.phase = PH_PAY;
                if (ctrl_q.len == '0) begin
                    ctrl_d.left = '0;
                end else begin
                    ctrl_d.left = {ctrl_q.len, 1'b0} - PAY_W'(2);
                end
            end
            PH_PAY: begin
                adv_d = 1'b1;
                if (ctrl_q.left == '0) begin
                    ctrl_d.phase = PH_GAP;
                    ctrl_d.cnt   = '0;
                end else begin
                    ctrl_d.left = ctrl_q.left - 1'b1;
                end
            end
            PH_GAP: begin
                if (ctrl_q.cnt == CNT_W'(GAP_N - 1)) begin
                    ctrl_d.cnt = '0;
                    if (ctrl_q.stop_pend | stop_i) begin
                        ctrl_d.phase     = PH_IDLE;
                        ctrl_d.stop_pend = 1'b0;
                    end else begin
                        ctrl_d.phase     = PH_PRE;
                        ctrl_d.len       = len_i;
                        ctrl_d.stop_pend = 1'b0;
                    end
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: begin
                ctrl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.phase     <= PH_IDLE;
            ctrl_q.cnt       <= '0;
            ctrl_q.left      <= '0;
            ctrl_q.len       <= '0;
            ctrl_q.stop_pend <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign phase_o   = ctrl_q.phase;
    assign pay_adv_o = adv_d;

endmodule

// File: rtl/bist_tx_path.sv
// Holds the sequence register and selects the nibble for the current phase.
module bist_tx_path
    import prbs_bist_pkg::*;
#(
    parameter int unsigned LFSR_W = 15,
    parameter int unsigned TAP_A  = 15,
    parameter int unsigned TAP_B  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase_i,
    input  logic              adv_i,
    output logic [NIB_W-1:0]  txd_o,
    output logic              tx_en_o,
    output logic [LFSR_W-1:0] lfsr_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } path_t;

    path_t             path_d, path_q;
    logic [LFSR_W-1:0] lfsr_nxt;
    logic [NIB_W-1:0]  pay_bits;

    prbs_nib_step #(
        .LFSR_W (LFSR_W),
        .TAP_A  (TAP_A),
        .TAP_B  (TAP_B),
        .STEPS  (NIB_W)
    ) u_step (
        .state_i (path_q.lfsr),
        .state_o (lfsr_nxt),
        .bits_o  (pay_bits)
    );

    always_comb begin
        path_d = path_q;
        if (adv_i) begin
            path_d.lfsr = lfsr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path_q.lfsr <= '1;
        end else begin
            path_q <= path_d;
        end
    end

    always_comb begin
        tx_en_o = 1'b1;
        txd_o   = '0;
        case (phase_i)
            PH_PRE:  txd_o = NIB_PRE;
            PH_SFD:  txd_o = NIB_SFD;
            PH_XTRA: txd_o = NIB_XTRA;
            PH_PAY:  txd_o = pay_bits;
            default: tx_en_o = 1'b0;
        endcase
    end

    assign lfsr_o = path_q.lfsr;

endmodule

// File: rtl/prbs_bist_gen.sv
module prbs_bist_gen
    import prbs_bist_pkg::*;
#(
    parameter int unsigned LEN_W        = 12,
    parameter int unsigned PRE_NIBBLES  = 15,
    parameter int unsigned GAP_NIBBLES  = 24,
    parameter int unsigned LFSR_W       = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [3:0]       txd_o,
    output logic             tx_en_o
);

    phase_t            phase;
    logic              pay_adv;
    logic [LFSR_W-1:0] lfsr_q;

    bist_frame_ctrl #(
        .LEN_W (LEN_W),
        .PRE_N (PRE_NIBBLES),
        .GAP_N (GAP_NIBBLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .len_i     (len_i),
        .phase_o   (phase),
        .pay_adv_o (pay_adv)
    );

    bist_tx_path #(
        .LFSR_W (LFSR_W),
        .TAP_A  (15),
        .TAP_B  (14)
    ) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .adv_i   (pay_adv),
        .txd_o   (txd_o),
        .tx_en_o (tx_en_o),
        .lfsr_o  (lfsr_q)
    );

endmodule

// File: rtl/prbs_bist_sva.sv
module prbs_bist_sva #(
    parameter int unsigned GAP_N  = 24,
    parameter int unsigned LFSR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        txd_o,
    input logic              tx_en_o,
    input logic [LFSR_W-1:0] lfsr_q
);

    logic [15:0] low_cnt;
    logic        seen_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt    <= '0;
            seen_frame <= 1'b0;
        end else if (tx_en_o) begin
            low_cnt    <= '0;
            seen_frame <= 1'b1;
        end else if (low_cnt != 16'hFFFF) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R11
    p_quiet_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_o |-> txd_o == 4'h0);

    // R10
    p_lfsr_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R6
    p_lfsr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_o |=> $stable(lfsr_q));

    // R7
    p_gap_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_frame && $rose(tx_en_o)) |-> low_cnt >= 16'(GAP_N));

    // R2
    p_first_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> txd_o == 4'h5);

endmodule

bind prbs_bist_gen prbs_bist_sva #(
    .GAP_N  (GAP_NIBBLES),
    .LFSR_W (LFSR_W)
) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .txd_o   (txd_o),
    .tx_en_o (tx_en_o),
    .lfsr_q  (lfsr_q)
);

// File: tb/prbs_bist_gen_tb.sv
module prbs_bist_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             stop = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic [3:0]       txd;
    logic             tx_en;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prbs_bist_gen u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .stop_i  (stop),
        .len_i   (len),
        .txd_o   (txd),
        .tx_en_o (tx_en)
    );

    // Reference model: item = {kind[2:0], en, nibble[3:0]}
    // kind 0 idle, 1 preamble, 2 delimiter, 3 extra, 4 payload, 5 gap
    logic [7:0] fq[$];
    int         exp_len[$];
    logic [7:0] cur = 8'h00;
    bit         running = 0;
    bit         stop_pend = 0;
    int         seq = 'h7FFF;

    function automatic logic [3:0] next_nib();
        logic [3:0] n;
        for (int b = 0; b < 4; b++) begin
            int fb;
            fb   = ((seq >> 14) ^ (seq >> 13)) & 1;
            seq  = ((seq << 1) | fb) & 'h7FFF;
            n[b] = fb[0];
        end
        return n;
    endfunction

    task automatic build_frame(input int nbytes);
        int npay;
        npay = (nbytes == 0) ? 1 : 2 * nbytes - 1;
        for (int i = 0; i < 15; i++) fq.push_back({3'd1, 1'b1, 4'h5});
        fq.push_back({3'd2, 1'b1, 4'hD});
        fq.push_back({3'd3, 1'b1, 4'h5});
        for (int i = 0; i < npay; i++) fq.push_back({3'd4, 1'b1, next_nib()});
        for (int i = 0; i < 24; i++) fq.push_back({3'd5, 1'b0, 4'h0});
        exp_len.push_back(17 + npay);
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fq.delete();
            exp_len.delete();
            cur       = 8'h00;
            running   = 0;
            stop_pend = 0;
            seq       = 'h7FFF;
        end else if (!running) begin
            if (start) begin
                running   = 1;
                stop_pend = stop;
                build_frame(int'(len));
                cur = fq.pop_front();
            end else begin
                cur = 8'h00;
            end
        end else begin
            stop_pend = stop_pend | stop;
            if (fq.size() > 0) begin
                cur = fq.pop_front();
            end else if (stop_pend) begin
                running   = 0;
                stop_pend = 0;
                cur       = 8'h00;
            end else begin
                build_frame(int'(len));
                cur = fq.pop_front();
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cycles, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    int run_cnt = 0;
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            string tag;
            case (cur[7:5])
                3'd1, 3'd2, 3'd3: tag = "R2/R3";
                3'd4:             tag = "R5/R6/R10";
                3'd5:             tag = "R7/R11";
                default:          tag = "R8/R9";
            endcase
            check({tx_en, txd} == cur[4:0], tag, {tx_en, txd}, cur[4:0]);
            if (tx_en) begin
                run_cnt++;
            end else if (run_cnt > 0) begin
                // R4: strobe-high length of each frame
                int e;
                e = (exp_len.size() > 0) ? exp_len.pop_front() : -1;
                check(run_cnt == e, "R4", run_cnt, e);
                run_cnt = 0;
            end
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (running) @(negedge clk);
    endtask

    initial begin
        wait_cycles(5);
        // R1: reset values
        check(tx_en == 1'b0 && txd == 4'h0, "R1", {tx_en, txd}, 0);
        rst_n = 1'b1;
        wait_cycles(2);
        check(tx_en == 1'b0 && txd == 4'h0, "R1", {tx_en, txd}, 0);

        // R8: stop while idle is ignored
        pulse_stop();
        wait_cycles(10);

        // R2, R3, R5: run frames of 4 bytes; start during a frame is ignored
        len = 12'd4;
        pulse_start();
        wait_cycles(30);
        pulse_start();
        wait_cycles(90);

        // R4: one-byte, zero-byte and 256-byte payloads
        len = 12'd1;
        wait_cycles(100);
        len = 12'd0;
        wait_cycles(100);
        len = 12'd256;
        wait_cycles(1200);

        // R8: stop in mid-frame
        len = 12'd3;
        pulse_stop();
        wait_idle();
        wait_cycles(30);

        // R8: stop in the last gap cycle
        pulse_start();
        while (!(running && fq.size() == 0)) @(negedge clk);
        pulse_stop();
        wait_idle();
        wait_cycles(40);

        // R9: start and stop in the same idle cycle
        len   = 12'd2;
        start = 1'b1;
        stop  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stop  = 1'b0;
        wait_idle();
        wait_cycles(40);
        check(tx_en == 1'b0, "R9", tx_en, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule